// File: doc/BRIEF.md
# Memory Window Address Translator

This block maps host memory accesses onto a removable card's address space through a small set of programmable windows. Each window covers a contiguous run of 4 KB host pages, from a start page to an inclusive stop page, and carries a 14-bit page offset. The offset is added to the host page number, wrapping inside 14 bits, to form the card page. Each window also has three flags: a 16-bit data-path flag, a timing-set flag and a flag that selects attribute space instead of common space.

Software programs the windows through byte-wide indexed registers. Every window owns a block of eight indices starting at a base index. A separate enable register holds one bit per window. Software clears a window's enable bit before it rewrites the window's fields.

On every host lookup the block tests all enabled windows in parallel. If more than one window matches, the lowest-numbered one wins. One clock later the block presents a hit flag, the winning window number, the 26-bit card address and that window's flags.

Top module: `mwt_translator`

## Requirements
- R1: After reset all windows are disabled, `hit_o` is low, and every register index reads back 0x00.
- R2: Window n's fields live at index 0x10 + 8*n and are laid out as follows.
  - Offset 0 holds start page bits 7:0. Offset 1 holds start page bits 11:8 in bits 3:0 and the 16-bit flag in bit 7.
  - Offset 2 holds stop page bits 7:0. Offset 3 holds stop page bits 11:8 in bits 3:0 and the timing-set flag in bit 6.
  - Offset 4 holds card offset bits 7:0. Offset 5 holds card offset bits 13:8 in bits 5:0 and the attribute flag in bit 6.
  - Bits that hold no field read back as 0.
- R3: The enable register sits at index 0x06, with bit n enabling window n. Its upper bits read back as 0. Writes are ignored, and reads return 0x00, at offsets 6 and 7 of a window block and at any index that belongs to no register.
- R4: A lookup hits a window when that window is enabled and start page <= host address bits 23:12 <= stop page. Both bounds are inclusive.
- R5: On a hit, the card address is {(host page + card offset) mod 2^14, host address bits 11:0}.
- R6: The offset addition wraps modulo 2^26 on the card address. An offset of 0x3FFF therefore maps a host page onto the page just below it.
- R7: When several enabled windows match, the lowest-numbered one drives the outputs and `win_o`.
- R8: `attr_o`, `wide16_o` and `timer1_o` carry the flags of the winning window.
- R9: Results are registered. They appear on the clock edge that samples `host_valid_i`. A cycle without `host_valid_i`, or a lookup with no match, leaves `hit_o` low and the other outputs at zero.
- R10: A disabled window never hits, even when the address lies inside its range. A change to the enable register applies to lookups from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_idx_i | input | 8 | Register index |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data |
| host_valid_i | input | 1 | Lookup request |
| host_addr_i | input | 24 | Host memory address |
| hit_o | output | 1 | Lookup matched an enabled window |
| win_o | output | 3 | Number of the winning window |
| card_addr_o | output | 26 | Translated card address |
| attr_o | output | 1 | Winning window targets attribute space |
| wide16_o | output | 1 | Winning window uses a 16-bit data path |
| timer1_o | output | 1 | Winning window uses timing set 1 |

## Verification
A lookup driven before a rising edge shows its result on every translation output right after that edge. The bench therefore drives requests on the falling edge and samples all outputs on the next falling edge. A register write lands on the edge that samples it. The bench waits until that write has settled before it starts a dependent lookup, so the test of R10's next-edge rule is exact. Read data is also registered and is sampled one edge after the read strobe.

// File: rtl/mwt_pkg.sv
package mwt_pkg;
  localparam int PAGE_W   = 12;
  localparam int OFF_W    = 14;
  localparam int PG_SHIFT = 12;
  localparam int HOST_W   = PAGE_W + PG_SHIFT;
  localparam int CARD_W   = OFF_W + PG_SHIFT;
  localparam int BLK_W    = 3;

  localparam logic [BLK_W-1:0] OFS_START_LO = 3'd0;
  localparam logic [BLK_W-1:0] OFS_START_HI = 3'd1;
  localparam logic [BLK_W-1:0] OFS_STOP_LO  = 3'd2;
  localparam logic [BLK_W-1:0] OFS_STOP_HI  = 3'd3;
  localparam logic [BLK_W-1:0] OFS_OFF_LO   = 3'd4;
  localparam logic [BLK_W-1:0] OFS_OFF_HI   = 3'd5;

  localparam int BIT_WIDE16 = 7;
  localparam int BIT_TIMER1 = 6;
  localparam int BIT_ATTR   = 6;

  typedef struct packed {
    logic [PAGE_W-1:0] start_pg;
    logic [PAGE_W-1:0] stop_pg;
    logic [OFF_W-1:0]  card_off;
    logic              wide16;
    logic              timer1;
    logic              attr;
  } win_cfg_t;
endpackage

// File: rtl/mwt_regfile.sv
module mwt_regfile
  import mwt_pkg::*;
#(
  parameter int              NUM_WIN  = 5,
  parameter int              IDX_W    = 8,
  parameter logic [IDX_W-1:0] WIN_BASE = 8'h10,
  parameter logic [IDX_W-1:0] EN_IDX   = 8'h06
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output win_cfg_t         cfg_o [NUM_WIN],
  output logic [NUM_WIN-1:0] en_o
);
  localparam int BLK_IDX_W = IDX_W - BLK_W;
  localparam int BASE_BLK  = int'(WIN_BASE) >> BLK_W;

  logic [7:0]         rb [NUM_WIN];
  logic [NUM_WIN-1:0] en_q;
  logic               en_sel;
  logic [BLK_W-1:0]   ofs;

  assign en_sel = (idx_i == EN_IDX);
  assign ofs    = idx_i[BLK_W-1:0];
  assign en_o   = en_q;

  always_ff @(posedge clk) begin
    if (rst)                  en_q <= '0;
    else if (wr_i && en_sel)  en_q <= wdata_i[NUM_WIN-1:0];
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    win_cfg_t cfg_q;
    logic     sel;

    assign sel = (idx_i[IDX_W-1:BLK_W] == BLK_IDX_W'(BASE_BLK + g));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q <= '0;
      end else if (wr_i && sel) begin
        case (ofs)
          OFS_START_LO: cfg_q.start_pg[7:0] <= wdata_i;
          OFS_START_HI: begin
            cfg_q.start_pg[PAGE_W-1:8] <= wdata_i[PAGE_W-9:0];
            cfg_q.wide16               <= wdata_i[BIT_WIDE16];
          end
          OFS_STOP_LO:  cfg_q.stop_pg[7:0] <= wdata_i;
          OFS_STOP_HI: begin
            cfg_q.stop_pg[PAGE_W-1:8] <= wdata_i[PAGE_W-9:0];
            cfg_q.timer1              <= wdata_i[BIT_TIMER1];
          end
          OFS_OFF_LO:   cfg_q.card_off[7:0] <= wdata_i;
          OFS_OFF_HI: begin
            cfg_q.card_off[OFF_W-1:8] <= wdata_i[OFF_W-9:0];
            cfg_q.attr                <= wdata_i[BIT_ATTR];
          end
          default: ;
        endcase
      end
    end

    always_comb begin
      rb[g] = '0;
      if (sel) begin
        case (ofs)
          OFS_START_LO: rb[g] = cfg_q.start_pg[7:0];
          OFS_START_HI: begin
            rb[g][PAGE_W-9:0]  = cfg_q.start_pg[PAGE_W-1:8];
            rb[g][BIT_WIDE16]  = cfg_q.wide16;
          end
          OFS_STOP_LO:  rb[g] = cfg_q.stop_pg[7:0];
          OFS_STOP_HI: begin
            rb[g][PAGE_W-9:0]  = cfg_q.stop_pg[PAGE_W-1:8];
            rb[g][BIT_TIMER1]  = cfg_q.timer1;
          end
          OFS_OFF_LO:   rb[g] = cfg_q.card_off[7:0];
          OFS_OFF_HI: begin
            rb[g][OFF_W-9:0]   = cfg_q.card_off[OFF_W-1:8];
            rb[g][BIT_ATTR]    = cfg_q.attr;
          end
          default: rb[g] = '0;
        endcase
      end
    end

    assign cfg_o[g] = cfg_q;
  end

  logic [7:0] rb_all;
  always_comb begin
    rb_all = en_sel ? 8'(en_q) : 8'h00;
    for (int i = 0; i < NUM_WIN; i++) rb_all = rb_all | rb[i];
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= rb_all;
  end
endmodule

// File: rtl/mwt_win_match.sv
module mwt_win_match
  import mwt_pkg::*;
(
  input  win_cfg_t          cfg_i,
  input  logic              en_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              match_o,
  output logic [OFF_W-1:0]  card_pg_o
);
  logic above_start;
  logic below_stop;

  assign above_start = (page_i >= cfg_i.start_pg);
  assign below_stop  = (page_i <= cfg_i.stop_pg);
  assign match_o     = en_i && above_start && below_stop;
  assign card_pg_o   = {{(OFF_W-PAGE_W){1'b0}}, page_i} + cfg_i.card_off;
endmodule

// File: rtl/mwt_prio_sel.sv
module mwt_prio_sel #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/mwt_translator.sv
module mwt_translator
  import mwt_pkg::*;
#(
  parameter int               NUM_WIN  = 5,
  parameter int               IDX_W    = 8,
  parameter logic [IDX_W-1:0] WIN_BASE = 8'h10,
  parameter logic [IDX_W-1:0] EN_IDX   = 8'h06,
  localparam int              WIN_IW   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              host_valid_i,
  input  logic [HOST_W-1:0] host_addr_i,
  output logic              hit_o,
  output logic [WIN_IW-1:0] win_o,
  output logic [CARD_W-1:0] card_addr_o,
  output logic              attr_o,
  output logic              wide16_o,
  output logic              timer1_o
);
  win_cfg_t           cfg [NUM_WIN];
  logic [NUM_WIN-1:0] win_en;
  logic [NUM_WIN-1:0] match_vec;
  logic [OFF_W-1:0]   card_pg [NUM_WIN];
  logic [PAGE_W-1:0]  host_pg;
  logic               any_hit;
  logic [WIN_IW-1:0]  win_sel;

  assign host_pg = host_addr_i[HOST_W-1:PG_SHIFT];

  mwt_regfile #(
    .NUM_WIN (NUM_WIN),
    .IDX_W   (IDX_W),
    .WIN_BASE(WIN_BASE),
    .EN_IDX  (EN_IDX)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (reg_wr_i),
    .rd_i   (reg_rd_i),
    .idx_i  (reg_idx_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .cfg_o  (cfg),
    .en_o   (win_en)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
    mwt_win_match u_match (
      .cfg_i    (cfg[g]),
      .en_i     (win_en[g]),
      .page_i   (host_pg),
      .match_o  (match_vec[g]),
      .card_pg_o(card_pg[g])
    );
  end

  mwt_prio_sel #(.N(NUM_WIN), .IW(WIN_IW)) u_prio (
    .req_i(match_vec),
    .any_o(any_hit),
    .idx_o(win_sel)
  );

  always_ff @(posedge clk) begin
    if (rst || !(host_valid_i && any_hit)) begin
      hit_o       <= 1'b0;
      win_o       <= '0;
      card_addr_o <= '0;
      attr_o      <= 1'b0;
      wide16_o    <= 1'b0;
      timer1_o    <= 1'b0;
    end else begin
      hit_o       <= 1'b1;
      win_o       <= win_sel;
      card_addr_o <= {card_pg[win_sel], host_addr_i[PG_SHIFT-1:0]};
      attr_o      <= cfg[win_sel].attr;
      wide16_o    <= cfg[win_sel].wide16;
      timer1_o    <= cfg[win_sel].timer1;
    end
  end
endmodule

// File: rtl/mwt_translator_chk.sv
module mwt_translator_chk
  import mwt_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int WIN_IW  = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               host_valid_i,
  input logic [HOST_W-1:0]  host_addr_i,
  input logic [NUM_WIN-1:0] win_en,
  input logic [NUM_WIN-1:0] match_vec,
  input logic               hit_o,
  input logic [WIN_IW-1:0]  win_o,
  input logic [CARD_W-1:0]  card_addr_o
);
  logic [NUM_WIN-1:0] en_d;
  logic [NUM_WIN-1:0] mv_d;
  logic [HOST_W-1:0]  addr_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d   <= '0;
      mv_d   <= '0;
      addr_d <= '0;
    end else begin
      en_d   <= win_en;
      mv_d   <= match_vec;
      addr_d <= host_addr_i;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !hit_o);

  p_idle_no_hit_r9: assert property (@(posedge clk) disable iff (rst)
    !host_valid_i |=> !hit_o);

  p_hit_tracks_match_r4: assert property (@(posedge clk) disable iff (rst)
    host_valid_i |=> (hit_o == $past(|match_vec)));

  p_hit_enabled_r10: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> en_d[win_o]);

  p_low_bits_r5: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (card_addr_o[PG_SHIFT-1:0] == addr_d[PG_SHIFT-1:0]));

  p_lowest_wins_r7: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> ((mv_d & ((NUM_WIN'(1) << win_o) - NUM_WIN'(1))) == '0));
endmodule

bind mwt_translator mwt_translator_chk #(
  .NUM_WIN(NUM_WIN),
  .WIN_IW (WIN_IW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_valid_i(host_valid_i),
  .host_addr_i (host_addr_i),
  .win_en      (win_en),
  .match_vec   (match_vec),
  .hit_o       (hit_o),
  .win_o       (win_o),
  .card_addr_o (card_addr_o)
);

// File: tb/mwt_translator_tb.sv
`timescale 1ns/1ps
module mwt_translator_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [7:0]  reg_idx_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        host_valid_i = 1'b0;
  logic [23:0] host_addr_i = '0;
  logic        hit_o;
  logic [2:0]  win_o;
  logic [25:0] card_addr_o;
  logic        attr_o, wide16_o, timer1_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  mwt_translator u_dut (
    .clk(clk), .rst(rst),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_idx_i(reg_idx_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .host_valid_i(host_valid_i), .host_addr_i(host_addr_i),
    .hit_o(hit_o), .win_o(win_o), .card_addr_o(card_addr_o),
    .attr_o(attr_o), .wide16_o(wide16_o), .timer1_o(timer1_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_idx_i = idx; reg_wdata_i = val;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] idx, input logic [7:0] exp);
    @(negedge clk);
    reg_rd_i = 1'b1; reg_idx_i = idx;
    @(negedge clk);
    reg_rd_i = 1'b0;
    check(req, 32'(reg_rdata_o), 32'(exp));
  endtask

  task automatic look(input string req, input logic [23:0] addr, input logic exp_hit,
                      input logic [2:0] exp_win, input logic [25:0] exp_card,
                      input logic exp_attr, input logic exp_wide, input logic exp_t1);
    @(negedge clk);
    host_valid_i = 1'b1; host_addr_i = addr;
    @(negedge clk);
    host_valid_i = 1'b0;
    check({req, " hit"}, 32'(hit_o), 32'(exp_hit));
    if (exp_hit) begin
      check({req, " win"},  32'(win_o), 32'(exp_win));
      check({req, " card"}, 32'(card_addr_o), 32'(exp_card));
      check({req, " attr"}, 32'(attr_o), 32'(exp_attr));
      check({req, " wide"}, 32'(wide16_o), 32'(exp_wide));
      check({req, " t1"},   32'(timer1_o), 32'(exp_t1));
    end else begin
      check({req, " card zero"}, 32'(card_addr_o), 32'h0);
    end
  endtask

  task automatic t_reset();
    check("R1 hit after reset", 32'(hit_o), 32'h0);
    rd_check("R1 enable reads 0", 8'h06, 8'h00);
    rd_check("R1 window reads 0", 8'h11, 8'h00);
    look("R1 lookup before enable", 24'h000123, 1'b0, 3'd0, 26'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_program();
    wr(8'h10, 8'h00); wr(8'h11, 8'h81); wr(8'h12, 8'hFF); wr(8'h13, 8'h01);
    wr(8'h14, 8'h50); wr(8'h15, 8'h00);
    wr(8'h18, 8'h00); wr(8'h19, 8'h0F); wr(8'h1A, 8'hFF); wr(8'h1B, 8'h0F);
    wr(8'h1C, 8'h00); wr(8'h1D, 8'h32);
    wr(8'h20, 8'h80); wr(8'h21, 8'h01); wr(8'h22, 8'h80); wr(8'h23, 8'h42);
    wr(8'h24, 8'h00); wr(8'h25, 8'h40);
    wr(8'h30, 8'h00); wr(8'h31, 8'h05); wr(8'h32, 8'h00); wr(8'h33, 8'h05);
    wr(8'h34, 8'h00); wr(8'h35, 8'h01);
    rd_check("R2 start hi with wide flag", 8'h11, 8'h81);
    rd_check("R2 stop hi with timer flag", 8'h23, 8'h42);
    rd_check("R2 offset hi with attr flag", 8'h25, 8'h40);
    rd_check("R2 window 4 offset lo", 8'h34, 8'h00);
    look("R10 disabled in range", 24'h100ABC, 1'b0, 3'd0, 26'h0, 1'b0, 1'b0, 1'b0);
    wr(8'h06, 8'h17);
    rd_check("R3 enable readback", 8'h06, 8'h17);
  endtask

  task automatic t_ranges();
    look("R5 basic translate",   24'h100ABC, 1'b1, 3'd0, 26'h0150ABC, 1'b0, 1'b1, 1'b0);
    look("R4 below start",       24'h0FFFFF, 1'b0, 3'd0, 26'h0, 1'b0, 1'b0, 1'b0);
    look("R7 overlap lowest",    24'h1FF123, 1'b1, 3'd0, 26'h024F123, 1'b0, 1'b1, 1'b0);
    look("R8 window 2 flags",    24'h200000, 1'b1, 3'd2, 26'h0200000, 1'b1, 1'b0, 1'b1);
    look("R4 stop inclusive",    24'h280FFF, 1'b1, 3'd2, 26'h0280FFF, 1'b1, 1'b0, 1'b1);
    look("R4 above stop",        24'h281000, 1'b0, 3'd0, 26'h0, 1'b0, 1'b0, 1'b0);
    look("R2 window 4 block",    24'h500777, 1'b1, 3'd4, 26'h0600777, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_wrap();
    look("R6 wrap past top",     24'hF10345, 1'b1, 3'd1, 26'h0110345, 1'b0, 1'b0, 1'b0);
    wr(8'h06, 8'h15);
    wr(8'h1C, 8'hFF); wr(8'h1D, 8'h3F);
    wr(8'h06, 8'h17);
    look("R6 offset minus one",  24'hF10345, 1'b1, 3'd1, 26'h0F0F345, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_enable();
    @(negedge clk);
    reg_wr_i = 1'b1; reg_idx_i = 8'h06; reg_wdata_i = 8'h16;
    host_valid_i = 1'b1; host_addr_i = 24'h1C0000;
    @(negedge clk);
    reg_wr_i = 1'b0; host_valid_i = 1'b0;
    check("R10 same-edge lookup uses old enable win", 32'(win_o), 32'd0);
    look("R10 window 0 off",     24'h1C0000, 1'b1, 3'd2, 26'h01C0000, 1'b1, 1'b0, 1'b1);
    look("R10 disabled only",    24'h100000, 1'b0, 3'd0, 26'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    check("R9 idle no hit", 32'(hit_o), 32'h0);
  endtask

  task automatic t_ignored();
    wr(8'h16, 8'hAA);
    rd_check("R3 block offset 6 ignored", 8'h16, 8'h00);
    wr(8'h05, 8'hAA);
    rd_check("R3 unmapped index ignored", 8'h05, 8'h00);
    wr(8'h38, 8'hAA);
    rd_check("R3 beyond last window", 8'h38, 8'h00);
    look("R3 lookup unchanged",  24'h1FF123, 1'b1, 3'd2, 26'h01FF123, 1'b1, 1'b0, 1'b1);
    wr(8'h06, 8'hFF);
    rd_check("R3 enable upper bits", 8'h06, 8'h1F);
    look("R7 window 3 at page 0", 24'h000123, 1'b1, 3'd3, 26'h0000123, 1'b0, 1'b0, 1'b0);
    look("R7 w0 beats w2 again",  24'h1C0010, 1'b1, 3'd0, 26'h0210010, 1'b0, 1'b1, 1'b0);
    wr(8'h35, 8'hFF);
    rd_check("R2 offset hi mask", 8'h35, 8'h7F);
    wr(8'h33, 8'hFF);
    rd_check("R2 stop hi mask", 8'h33, 8'h4F);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_program();
    t_ranges();
    t_wrap();
    t_enable();
    t_ignored();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule